// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer that joins two independent clock domains. Words of 18 bits enter on the write clock and leave on the read clock, with up to 1024 words held in between. Each side has an active-low enable. The block drives five active-low status flags: empty, full, almost-empty, almost-full and half-full.

The almost-empty and almost-full thresholds live in a small offset register. Software or a controller reaches this register through the FIFO's own data buses while the active-low load input is held low. In that mode, write-side accesses store thresholds and read-side accesses return them. The selector alternates between the two thresholds, starting with almost-empty.

An active-low rewind strobe on the read clock moves the read pointer back to zero, so the stored stream can be read again. While rewind is held low, no data word is accepted on either side. Pointers cross between the domains as Gray code through a chain of synchronizer flops. As a result, a flag asserts at once in its own domain and releases only after the synchronizer latency.

Top module: `pflag_fifo`

## Requirements
- R1: A write-clock edge with `wr_en_n` low, `load_n` high, `rewind_n` high and `full_n` high stores `din`. Words leave in the order they were stored, with their values unchanged.
- R2: A read-clock edge with `rd_en_n` low, `load_n` high, `rewind_n` high and `empty_n` high places the oldest word on `dout`, visible after that edge. A read request while `empty_n` is low leaves `dout` and the read pointer unchanged.
- R3: `empty_n` is low when no word is held. It falls right after the read edge that removes the last word. With equal clocks, it rises after the second read-clock edge that follows the write edge storing the first word.
- R4: `full_n` is low when 1024 words are held, and write requests made then are discarded. After a read, `full_n` returns high once the read pointer has crossed into the write domain.
- R5: `aempty_n` is low whenever the held-word count is less than or equal to the almost-empty threshold. It is low whenever `empty_n` is low.
- R6: `afull_n` is low whenever the free space (1024 minus the held-word count) is less than or equal to the almost-full threshold.
- R7: `half_n` is low when more than 512 words are held, judged in the write domain. It is high at exactly 512 words.
- R8: With `load_n` low, a write-enabled write edge stores `din[9:0]` into the threshold register and puts nothing into the FIFO. Successive stores go to almost-empty first, then almost-full, then wrap back to almost-empty.
- R9: With `load_n` low, a read-enabled read edge drives the selected threshold onto `dout[9:0]`, with `dout[17:10]` zero. The read pointer does not advance. Successive reads alternate almost-empty, almost-full, and then wrap.
- R10: A read edge with `rewind_n` low sets the read pointer to zero, so the next reads return the stored stream from its first word. While `rewind_n` is low, data reads and data writes are not accepted.
- R11: While `rst_n` is low, both pointers are cleared and both thresholds become 63. After reset, `empty_n` and `aempty_n` are low and `full_n`, `afull_n` and `half_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_n | input | 1 | Active-low write request |
| rd_en_n | input | 1 | Active-low read request |
| load_n | input | 1 | Active-low selection of the threshold register on both data buses |
| rewind_n | input | 1 | Active-low rewind of the read pointer, sampled on rd_clk |
| din | input | 18 | Write data or threshold value |
| dout | output | 18 | Read data or threshold readback |
| empty_n | output | 1 | Low when the FIFO holds no word (read domain) |
| full_n | output | 1 | Low when the FIFO holds 1024 words (write domain) |
| aempty_n | output | 1 | Low when the count is at or below the almost-empty threshold (read domain) |
| afull_n | output | 1 | Low when the free space is at or below the almost-full threshold (write domain) |
| half_n | output | 1 | Low when more than 512 words are held (write domain) |

## Verification
The data path is tested in three ways:
- A short burst is written before any read. This separates correct ordering from a pointer that skips or repeats words.
- A full 1024-word fill with a non-repeating pattern is read back. This shows whether the address wraps correctly and whether a write offered while full was dropped or overwrote a stored word.
- A partial read is followed by a rewind. This shows whether the read pointer really returns to the first word, and whether a write offered during the rewind was blocked.

The flag thresholds are probed one word either side of each boundary (512/513, 1013/1014, 1023/1024, and the programmed almost-empty value). This catches comparisons that are off by one or use the wrong relational operator.

// File: rtl/pff_pkg.sv
package pff_pkg;
   // Which threshold a load-mode access addresses
   typedef enum logic {
      OFS_LOW  = 1'b0,   // almost-empty threshold
      OFS_HIGH = 1'b1    // almost-full threshold
   } ofs_sel_e;

   localparam int unsigned PFF_SYNC_MIN = 2;

   function automatic ofs_sel_e ofs_next(input ofs_sel_e s);
      return (s == OFS_LOW) ? OFS_HIGH : OFS_LOW;
   endfunction
endpackage

// File: rtl/pff_sync.sv
module pff_sync #(
   parameter int unsigned WIDTH  = 11,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   generate
      if (STAGES < pff_pkg::PFF_SYNC_MIN) begin : g_bad_stages
         $error("pff_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[STAGES-2:0], d};
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pff_g2b.sv
module pff_g2b #(
   parameter int unsigned WIDTH = 11
) (
   input  logic [WIDTH-1:0] gray,
   output logic [WIDTH-1:0] bin
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign bin[i] = ^gray[WIDTH-1:i];
      end
   endgenerate
endmodule

// File: rtl/pff_wr_side.sv
module pff_wr_side #(
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OFS_DEFAULT = 63,
   localparam int unsigned PTR_W      = ADDR_W + 1
) (
   input  logic              wr_clk,
   input  logic              rst_n,
   input  logic              wr_en_n,
   input  logic              load_n,
   input  logic              rewind_n,
   input  logic [ADDR_W-1:0] din_ofs,
   input  logic [PTR_W-1:0]  rgray_async,
   output logic              wr_fire,
   output logic [ADDR_W-1:0] waddr,
   output logic [PTR_W-1:0]  wgray_q,
   output logic [PTR_W-1:0]  wptr_q,
   output logic [PTR_W-1:0]  wcount,
   output logic [ADDR_W-1:0] ae_ofs_q,
   output logic [ADDR_W-1:0] af_ofs_q,
   output logic              full_n,
   output logic              afull_n,
   output logic              half_n
);
   import pff_pkg::*;

   localparam logic [PTR_W-1:0] DEPTH_V = {1'b1, {ADDR_W{1'b0}}};
   localparam logic [PTR_W-1:0] HALF_V  = {2'b01, {(ADDR_W-1){1'b0}}};

   logic [PTR_W-1:0] rgray_s, rbin_s, wptr_nxt, free_cnt;
   logic             ofs_wr;
   ofs_sel_e         wsel_q;

   pff_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_rsync (
      .clk(wr_clk), .rst_n(rst_n), .d(rgray_async), .q(rgray_s));

   pff_g2b #(.WIDTH(PTR_W)) u_rconv (.gray(rgray_s), .bin(rbin_s));

   assign wr_fire  = !wr_en_n && load_n && rewind_n && full_n;
   assign ofs_wr   = !wr_en_n && !load_n;
   assign wptr_nxt = wptr_q + PTR_W'(wr_fire);
   assign waddr    = wptr_q[ADDR_W-1:0];

   assign wcount   = wptr_q - rbin_s;
   assign free_cnt = DEPTH_V - wcount;
   assign full_n   = (wcount != DEPTH_V);
   assign afull_n  = !(free_cnt <= {1'b0, af_ofs_q});
   assign half_n   = !(wcount > HALF_V);

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         wgray_q <= '0;
      end else begin
         wptr_q  <= wptr_nxt;
         wgray_q <= wptr_nxt ^ (wptr_nxt >> 1);
      end
   end

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         ae_ofs_q <= ADDR_W'(OFS_DEFAULT);
         af_ofs_q <= ADDR_W'(OFS_DEFAULT);
         wsel_q   <= OFS_LOW;
      end else if (ofs_wr) begin
         if (wsel_q == OFS_LOW) ae_ofs_q <= din_ofs;
         else                   af_ofs_q <= din_ofs;
         wsel_q <= ofs_next(wsel_q);
      end
   end
endmodule

// File: rtl/pff_rd_side.sv
module pff_rd_side #(
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned PTR_W      = ADDR_W + 1
) (
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              rd_en_n,
   input  logic              load_n,
   input  logic              rewind_n,
   input  logic [PTR_W-1:0]  wgray_async,
   input  logic [ADDR_W-1:0] ae_ofs,
   output logic              rd_fire,
   output logic              ofs_rd,
   output pff_pkg::ofs_sel_e rsel_q,
   output logic [ADDR_W-1:0] raddr,
   output logic [PTR_W-1:0]  rgray_q,
   output logic [PTR_W-1:0]  rptr_q,
   output logic              empty_n,
   output logic              aempty_n
);
   import pff_pkg::*;

   logic [PTR_W-1:0] wgray_s, wbin_s, rptr_nxt, rcount;

   pff_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_wsync (
      .clk(rd_clk), .rst_n(rst_n), .d(wgray_async), .q(wgray_s));

   pff_g2b #(.WIDTH(PTR_W)) u_wconv (.gray(wgray_s), .bin(wbin_s));

   assign rd_fire  = !rd_en_n && load_n && rewind_n && empty_n;
   assign ofs_rd   = !rd_en_n && !load_n;
   assign rptr_nxt = rewind_n ? (rptr_q + PTR_W'(rd_fire)) : '0;
   assign raddr    = rptr_q[ADDR_W-1:0];

   assign rcount   = wbin_s - rptr_q;
   assign empty_n  = (rcount != '0);
   assign aempty_n = !(rcount <= {1'b0, ae_ofs});

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q  <= '0;
         rgray_q <= '0;
      end else begin
         rptr_q  <= rptr_nxt;
         rgray_q <= rptr_nxt ^ (rptr_nxt >> 1);
      end
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)      rsel_q <= OFS_LOW;
      else if (ofs_rd) rsel_q <= ofs_next(rsel_q);
   end
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo #(
   parameter int unsigned DATA_W      = 18,
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OFS_DEFAULT = 63
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_en_n,
   input  logic              rd_en_n,
   input  logic              load_n,
   input  logic              rewind_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              empty_n,
   output logic              full_n,
   output logic              aempty_n,
   output logic              afull_n,
   output logic              half_n
);
   import pff_pkg::*;

   localparam int unsigned PTR_W = ADDR_W + 1;
   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      if (DATA_W <= ADDR_W) begin : g_bad_width
         $error("pflag_fifo: DATA_W must exceed ADDR_W to carry thresholds");
      end
      if (ADDR_W < 2) begin : g_bad_depth
         $error("pflag_fifo: ADDR_W must be at least 2");
      end
      if (OFS_DEFAULT >= DEPTH) begin : g_bad_ofs
         $error("pflag_fifo: OFS_DEFAULT must be below the depth");
      end
   endgenerate

   logic              wr_fire, rd_fire, ofs_rd;
   logic [ADDR_W-1:0] waddr, raddr, ae_ofs, af_ofs;
   logic [PTR_W-1:0]  wgray, rgray, wptr_q, rptr_q, wcount;
   ofs_sel_e          rsel;
   logic [DATA_W-1:0] mem [DEPTH];

   pff_wr_side #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
                 .OFS_DEFAULT(OFS_DEFAULT)) u_wr (
      .wr_clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .load_n(load_n),
      .rewind_n(rewind_n), .din_ofs(din[ADDR_W-1:0]), .rgray_async(rgray),
      .wr_fire(wr_fire), .waddr(waddr), .wgray_q(wgray), .wptr_q(wptr_q),
      .wcount(wcount), .ae_ofs_q(ae_ofs), .af_ofs_q(af_ofs),
      .full_n(full_n), .afull_n(afull_n), .half_n(half_n));

   pff_rd_side #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
      .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .load_n(load_n),
      .rewind_n(rewind_n), .wgray_async(wgray), .ae_ofs(ae_ofs),
      .rd_fire(rd_fire), .ofs_rd(ofs_rd), .rsel_q(rsel), .raddr(raddr),
      .rgray_q(rgray), .rptr_q(rptr_q), .empty_n(empty_n),
      .aempty_n(aempty_n));

   always_ff @(posedge wr_clk) begin
      if (wr_fire) mem[waddr] <= din;
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)       dout <= '0;
      else if (ofs_rd)  dout <= DATA_W'((rsel == OFS_LOW) ? ae_ofs : af_ofs);
      else if (rd_fire) dout <= mem[raddr];
   end
endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk #(
   parameter int unsigned DATA_W = 18,
   parameter int unsigned ADDR_W = 10,
   localparam int unsigned PTR_W = ADDR_W + 1
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              rst_n,
   input logic              rd_en_n,
   input logic              load_n,
   input logic              rewind_n,
   input logic              full_n,
   input logic              empty_n,
   input logic              aempty_n,
   input logic [DATA_W-1:0] dout,
   input logic [PTR_W-1:0]  wptr_q,
   input logic [PTR_W-1:0]  rptr_q,
   input logic [PTR_W-1:0]  wcount
);
   localparam logic [PTR_W-1:0] DEPTH_V = {1'b1, {ADDR_W{1'b0}}};

   // R4
   no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |=> $stable(wptr_q));

   // R4
   count_bound_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      wcount <= DEPTH_V);

   // R2
   no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!empty_n && rewind_n) |=> $stable(rptr_q));

   // R10
   rewind_zero_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !rewind_n |=> (rptr_q == '0));

   // R8
   load_no_push_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !load_n |=> $stable(wptr_q));

   // R9
   ofs_upper_zero_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!load_n && !rd_en_n) |=> (dout[DATA_W-1:ADDR_W] == '0));

   // R5
   empty_implies_ae_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |-> !aempty_n);
endmodule

bind pflag_fifo pflag_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n),
   .load_n(load_n), .rewind_n(rewind_n), .full_n(full_n), .empty_n(empty_n),
   .aempty_n(aempty_n), .dout(dout), .wptr_q(wptr_q), .rptr_q(rptr_q),
   .wcount(wcount));

// File: tb/pflag_fifo_tb.sv
`timescale 1ns/1ps
module pflag_fifo_tb;
   logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic        wr_en_n = 1'b1, rd_en_n = 1'b1, load_n = 1'b1, rewind_n = 1'b1;
   logic [17:0] din = '0;
   logic [17:0] dout;
   logic        empty_n, full_n, aempty_n, afull_n, half_n;
   int          vecs = 0, errs = 0;
   bit          done = 1'b0;

   pflag_fifo u_dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
      .rd_en_n(rd_en_n), .load_n(load_n), .rewind_n(rewind_n), .din(din),
      .dout(dout), .empty_n(empty_n), .full_n(full_n), .aempty_n(aempty_n),
      .afull_n(afull_n), .half_n(half_n));

   // 200 MHz, both domains toggled together
   always #2.5 begin
      wr_clk = ~wr_clk;
      rd_clk = ~rd_clk;
   end

   function automatic logic [17:0] pat(input int i);
      return 18'((i * 37) ^ 18'h15A5A);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge wr_clk);
   endtask

   task automatic push(input logic [17:0] d);
      din = d; wr_en_n = 1'b0;
      @(negedge wr_clk);
      wr_en_n = 1'b1;
   endtask

   task automatic pop();
      rd_en_n = 1'b0;
      @(negedge rd_clk);
      rd_en_n = 1'b1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R11 empty_n", 32'(empty_n), 0);
      chk("R11 aempty_n", 32'(aempty_n), 0);
      chk("R11 full_n", 32'(full_n), 1);
      chk("R11 afull_n", 32'(afull_n), 1);
      chk("R11 half_n", 32'(half_n), 1);
   endtask

   task automatic t_offsets();
      load_n = 1'b0;
      pop(); chk("R11 default ae", 32'(dout), 63);
      pop(); chk("R9 default af", 32'(dout), 63);
      push(18'h3FC05);   // upper bits ignored, ae = 5
      push(18'h2000A);   // af = 10
      pop(); chk("R8 ae stored", 32'(dout), 5);
      pop(); chk("R9 af readback", 32'(dout), 10);
      pop(); chk("R9 selector wrap", 32'(dout), 5);
      load_n = 1'b1;
      idle(3);
      chk("R8 nothing queued", 32'(empty_n), 0);
   endtask

   task automatic t_flow();
      push(pat(0));
      idle(1);
      chk("R3 empty held during sync", 32'(empty_n), 0);
      idle(1);
      chk("R3 empty released", 32'(empty_n), 1);
      push(pat(1)); push(pat(2));
      idle(3);
      chk("R5 aempty at 3", 32'(aempty_n), 0);
      push(pat(3)); push(pat(4)); push(pat(5));
      idle(3);
      chk("R5 aempty at 6", 32'(aempty_n), 1);
      pop();
      chk("R1 order 0", 32'(dout), 32'(pat(0)));
      chk("R5 aempty at 5", 32'(aempty_n), 0);
      for (int i = 1; i < 6; i++) begin
         pop();
         chk("R1 order", 32'(dout), 32'(pat(i)));
      end
      chk("R3 empty on last read", 32'(empty_n), 0);
      pop();
      chk("R2 empty read holds dout", 32'(dout), 32'(pat(5)));
      chk("R2 still empty", 32'(empty_n), 0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < 1024; i++) begin
         push(pat(i + 100));
         if (i + 1 == 512)  chk("R7 half at 512", 32'(half_n), 1);
         if (i + 1 == 513)  chk("R7 half at 513", 32'(half_n), 0);
         if (i + 1 == 1013) chk("R6 afull free 11", 32'(afull_n), 1);
         if (i + 1 == 1014) chk("R6 afull free 10", 32'(afull_n), 0);
         if (i + 1 == 1023) chk("R4 full at 1023", 32'(full_n), 1);
         if (i + 1 == 1024) chk("R4 full at 1024", 32'(full_n), 0);
      end
      push(18'h3FFFF);
      idle(3);
      pop();
      chk("R4 first word kept", 32'(dout), 32'(pat(100)));
      idle(3);
      chk("R4 full released", 32'(full_n), 1);
      for (int i = 1; i < 1024; i++) begin
         pop();
         chk("R1 fill data", 32'(dout), 32'(pat(i + 100)));
      end
      chk("R4 write while full dropped", 32'(empty_n), 0);
   endtask

   task automatic t_rewind();
      do_reset();
      for (int i = 0; i < 4; i++) push(pat(i + 2000));
      idle(3);
      pop(); pop();
      chk("R2 partial read", 32'(dout), 32'(pat(2001)));
      din = 18'h00777; wr_en_n = 1'b0; rd_en_n = 1'b0; rewind_n = 1'b0;
      @(negedge rd_clk);
      wr_en_n = 1'b1; rd_en_n = 1'b1; rewind_n = 1'b1;
      chk("R10 read blocked in rewind", 32'(dout), 32'(pat(2001)));
      chk("R10 data available again", 32'(empty_n), 1);
      idle(3);
      for (int i = 0; i < 4; i++) begin
         pop();
         chk("R10 replay", 32'(dout), 32'(pat(i + 2000)));
      end
      chk("R10 write blocked in rewind", 32'(empty_n), 0);
   endtask

   initial begin
      t_reset();
      t_offsets();
      t_flow();
      t_fill();
      t_rewind();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      #(100000 * 5);
      if (!done) begin
         done = 1'b1;
         vecs++; errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end
endmodule